// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block is a first-in first-out buffer whose write side and read side run from unrelated clocks. Pointers are passed between the two clock domains as Gray codes through two-flop synchronisers. Words are 9 bits wide and the storage depth is a power of two set by a parameter. The output mode is captured while master reset is held. In standard mode, two active-low pins flag full and empty, and a word appears on the output one read-clock edge after a read request. In fall-through mode, the same two pins become "ready to accept" and "output holds data". The oldest word moves onto the output by itself, and the output register counts as one more storage slot.

Two offset registers set the thresholds of an almost-empty flag and an almost-full flag. Master reset loads both offsets with one of two defaults, picked by a select pin. The offsets can then be rewritten from the write side, but only while the buffer is idle. Partial reset empties the buffer and keeps the mode and both offsets. Master reset clears everything.

Top module: `dcfifo_ft`

## Requirements
- R1: In standard mode, with no reads since reset, `ff_ir_n` goes low right after the DEPTH-th accepted write. Any write while it is low is dropped and never reaches the output.
- R2: In standard mode, `ef_or_n` goes low once every stored word has been read. A read request while it is low leaves `dout` unchanged.
- R3: In fall-through mode, the oldest word appears on `dout` without a read request, and `ef_or_n` is low exactly while `dout` holds an unread word. Each read pulse advances to the next word.
- R4: In fall-through mode, `ff_ir_n` is low while space remains and goes high only after DEPTH+1 words are held. The output register is one of those words.
- R5: `pae_n` is low exactly when the occupancy is at or below the empty offset. Occupancy means the words in storage, plus one in fall-through mode while `dout` holds an unread word.
- R6: `paf_n` is low exactly when the free storage (DEPTH minus the words in storage) is at or below the full offset.
- R7: During master reset, both offsets load OFS_LO when `ld_sel` is 0 and OFS_HI when `ld_sel` is 1. The mode is taken from `mode_ft`, where 0 means standard and 1 means fall-through.
- R8: A write-clock cycle with `ofs_we` high stores `ofs_din` into the empty offset when `ofs_sel` is 0, and into the full offset when `ofs_sel` is 1. This replaces the whole register.
- R9: Partial reset empties the buffer and returns the flags to their reset levels. It keeps the captured mode and both offsets.
- R10: After master reset the buffer is empty and `dout` is 0. In standard mode `ef_or_n`=0, `ff_ir_n`=1, `pae_n`=0 and `paf_n`=1. In fall-through mode `ef_or_n`=1 and `ff_ir_n`=0.
- R11: Words leave in the order they were written. After the first write into an empty buffer, the empty indication is released only after the write pointer has passed the two read-clock synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low |
| prs_n | input | 1 | Partial reset, active low |
| mode_ft | input | 1 | Mode captured at master reset (1 = fall-through) |
| ld_sel | input | 1 | Offset default select captured at master reset |
| wen | input | 1 | Write request (write clock) |
| din | input | DW | Write data |
| ren | input | 1 | Read request (read clock) |
| dout | output | DW | Output data register |
| ofs_we | input | 1 | Offset write strobe (write clock) |
| ofs_sel | input | 1 | Offset target: 0 empty, 1 full |
| ofs_din | input | AW | Offset value |
| ff_ir_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| ef_or_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
The bench fills the buffer to the exact edge of full in both modes. A design that ignored the output register in fall-through mode would flag full one word early. A design that accepted a write while full would leak that word into the read-out. It drains to empty and then reads once more, so a design that still popped would change `dout`. Both almost-flags are stepped across their thresholds one word at a time. This exposes any comparison that is off by one, or that ignores the held output word. A partial reset between two rounds with programmed offsets shows whether the offsets or the mode were lost. The bench also samples the empty flag right after the first write, where a design without synchronisers would already show data.

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int DW     = 9,
  parameter int AW     = 4,
  parameter int OFS_LO = 2,
  parameter int OFS_HI = 5
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrs_n,
  input  logic          prs_n,
  input  logic          mode_ft,
  input  logic          ld_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ren,
  output logic [DW-1:0] dout,
  input  logic          ofs_we,
  input  logic          ofs_sel,
  input  logic [AW-1:0] ofs_din,
  output logic          ff_ir_n,
  output logic          ef_or_n,
  output logic          pae_n,
  output logic          paf_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rst_n;
  logic          ft;
  logic [AW-1:0] ofs_e, ofs_f;
  logic [DW-1:0] mem [DEPTH];

  assign rst_n = mrs_n & prs_n;

  // mode and offsets: loaded only by master reset or the offset strobe
  always_ff @(posedge wclk) begin
    if (!mrs_n) begin
      ft    <= mode_ft;
      ofs_e <= ld_sel ? AW'(OFS_HI) : AW'(OFS_LO);
      ofs_f <= ld_sel ? AW'(OFS_HI) : AW'(OFS_LO);
    end else if (ofs_we) begin
      if (ofs_sel) ofs_f <= ofs_din;
      else         ofs_e <= ofs_din;
    end
  end

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, rgray, wfill;
  logic          full, wr_go;

  assign wfill = wbin - g2b(rg_s2);
  assign full  = (wfill == PW'(DEPTH));
  assign wr_go = wen & ~full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin + PW'(1);
        wgray <= b2g(wbin + PW'(1));
      end
    end
  end

  always_ff @(posedge wclk) if (wr_go) mem[wbin[AW-1:0]] <= din;

  assign ff_ir_n = ft ? full : ~full;
  assign paf_n   = ~((PW'(DEPTH) - wfill) <= {1'b0, ofs_f});

  // read domain
  logic [PW-1:0] rbin, wg_s1, wg_s2, rfill, occ;
  logic          ov, empty, std_rd, ft_ld, pop;

  assign rfill  = g2b(wg_s2) - rbin;
  assign empty  = (rfill == '0);
  assign std_rd = ~ft & ren & ~empty;
  assign ft_ld  = ft & ~empty & (~ov | ren);
  assign pop    = std_rd | ft_ld;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      ov <= 1'b0; dout <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (pop) begin
        rbin  <= rbin + PW'(1);
        rgray <= b2g(rbin + PW'(1));
        dout  <= mem[rbin[AW-1:0]];
      end
      if (ft_ld)          ov <= 1'b1;
      else if (ft && ren) ov <= 1'b0;
    end
  end

  assign occ     = rfill + PW'(ft & ov);
  assign ef_or_n = ft ? ~ov : ~empty;
  assign pae_n   = ~(occ <= {1'b0, ofs_e});

  assert_no_overflow_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && !ff_ir_n && !ft) |=> $stable(wbin));
  assert_fill_bound_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    wfill <= PW'(DEPTH));
  assert_hold_when_empty_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ft && ren && !ef_or_n) |=> $stable(dout));
  assert_ft_consume_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(ov) |-> $past(ren));
  assert_gray_step_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(wg_s1 ^ $past(wg_s1)) <= 1);
  assert_gray_step_w_R11: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(rg_s1 ^ $past(rg_s1)) <= 1);
endmodule

// File: tb/tb_dcfifo_ft.sv
module tb_dcfifo_ft;
  localparam int DW = 9, AW = 4, DEPTH = 16, LO = 2, HI = 5;

  logic wclk = 0, rclk = 0;
  logic mrs_n = 0, prs_n = 1, mode_ft = 0, ld_sel = 0;
  logic wen = 0, ren = 0, ofs_we = 0, ofs_sel = 0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ofs_din = '0;
  logic [DW-1:0] dout;
  logic ff_ir_n, ef_or_n, pae_n, paf_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dcfifo_ft #(.DW(DW), .AW(AW), .OFS_LO(LO), .OFS_HI(HI)) dut (
    .wclk, .rclk, .mrs_n, .prs_n, .mode_ft, .ld_sel, .wen, .din, .ren, .dout,
    .ofs_we, .ofs_sel, .ofs_din, .ff_ir_n, .ef_or_n, .pae_n, .paf_n);

  function automatic logic [DW-1:0] val(int i);
    return DW'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic mreset(bit m, bit l);
    wen = 0; ren = 0; ofs_we = 0;
    mode_ft = m; ld_sel = l; mrs_n = 0;
    repeat (3) @(negedge wclk);
    repeat (2) @(negedge rclk);
    mrs_n = 1;
    settle();
  endtask

  task automatic preset();
    wen = 0; ren = 0; prs_n = 0;
    repeat (3) @(negedge wclk);
    repeat (2) @(negedge rclk);
    prs_n = 1;
    settle();
  endtask

  task automatic wr(logic [DW-1:0] d);
    @(negedge wclk); wen = 1; din = d;
    @(negedge wclk); wen = 0;
  endtask

  task automatic rd();
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
  endtask

  task automatic ld_ofs(bit s, logic [AW-1:0] v);
    @(negedge wclk); ofs_we = 1; ofs_sel = s; ofs_din = v;
    @(negedge wclk); ofs_we = 0;
  endtask

  initial begin
    // standard mode, default low offsets
    mreset(0, 0);
    chk("R10 ef", ef_or_n, 0); chk("R10 ff", ff_ir_n, 1);
    chk("R10 pae", pae_n, 0);  chk("R10 paf", paf_n, 1);
    chk("R10 dout", dout, 0);
    wr(val(0));
    chk("R11 ef not yet released", ef_or_n, 0);
    settle();
    chk("R11 ef released", ef_or_n, 1);
    for (int k = 2; k <= DEPTH; k++) begin
      wr(val(k - 1));
      chk("R1 ff during fill", ff_ir_n, (k == DEPTH) ? 0 : 1);
      chk("R6 R7 paf during fill", paf_n, (DEPTH - k <= LO) ? 0 : 1);
    end
    wr(9'h0AA);
    chk("R1 ff after extra write", ff_ir_n, 0);
    settle();
    chk("R5 pae when full", pae_n, 1);
    for (int j = 1; j <= DEPTH; j++) begin
      rd();
      chk("R11 order", dout, val(j - 1));
      chk("R2 ef during drain", ef_or_n, (j == DEPTH) ? 0 : 1);
      chk("R5 pae during drain", pae_n, (DEPTH - j <= LO) ? 0 : 1);
    end
    rd();
    chk("R2 dout held on empty read", dout, val(DEPTH - 1));
    chk("R2 ef stays low", ef_or_n, 0);

    // fall-through mode, default high offsets
    mreset(1, 1);
    chk("R10 ft or", ef_or_n, 1); chk("R10 ft ir", ff_ir_n, 0);
    wr(val(100));
    settle();
    chk("R3 or low with head word", ef_or_n, 0);
    chk("R3 head word on dout", dout, val(100));
    for (int k = 2; k <= DEPTH + 1; k++) begin
      wr(val(99 + k));
      chk("R4 ir during fill", ff_ir_n, (k == DEPTH + 1) ? 1 : 0);
    end
    wr(9'h0AA);
    chk("R4 ir after extra write", ff_ir_n, 1);
    settle();
    chk("R5 pae ft full", pae_n, 1);
    for (int j = 0; j <= DEPTH; j++) begin
      chk("R3 or before read", ef_or_n, 0);
      chk("R3 R11 ft order", dout, val(100 + j));
      rd();
      chk("R5 R7 ft pae", pae_n, (DEPTH - j <= HI) ? 0 : 1);
    end
    chk("R3 or high when drained", ef_or_n, 1);
    preset();
    chk("R9 ft or after prs", ef_or_n, 1);
    chk("R9 ft ir after prs", ff_ir_n, 0);
    wr(val(200));
    settle();
    chk("R9 mode kept", ef_or_n, 0);
    chk("R9 mode kept dout", dout, val(200));

    // programmed offsets and partial reset
    mreset(0, 0);
    ld_ofs(0, 4'd3);
    ld_ofs(1, 4'd4);
    for (int k = 1; k <= 12; k++) begin
      wr(val(300 + k));
      if (k >= 11) chk("R8 paf programmed", paf_n, (k == 12) ? 0 : 1);
    end
    settle();
    for (int j = 1; j <= 9; j++) begin
      rd();
      if (j >= 8) chk("R8 pae programmed", pae_n, (j == 9) ? 0 : 1);
    end
    preset();
    chk("R9 ef", ef_or_n, 0); chk("R9 ff", ff_ir_n, 1);
    chk("R9 pae", pae_n, 0);  chk("R9 paf", paf_n, 1);
    for (int k = 1; k <= 12; k++) begin
      wr(val(400 + k));
      if (k >= 11) chk("R9 offset kept", paf_n, (k == 12) ? 0 : 1);
    end
    mreset(0, 1);
    for (int k = 1; k <= 11; k++) begin
      wr(val(500 + k));
      if (k >= 10) chk("R7 high default", paf_n, (k == 11) ? 0 : 1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule